// File: doc/BRIEF.md
# Segment Descriptor Check Unit

This block sits next to a cached 64-bit segment descriptor and judges one memory access per request. For each request it takes a 32-bit offset, an access kind and the current privilege level. It applies the descriptor's present, type, privilege, direction and granularity rules. The result is either a 32-bit linear address, formed as base plus offset, or a fault with a cause code.

The result is registered and appears one cycle after the request. When an access succeeds through a descriptor whose accessed bit is still clear, the block also returns a copy of the descriptor with that bit set, so that the surrounding logic can write it back. Requests may arrive on every cycle.

Top module: `seg_check_unit`

## Requirements
- R1: Every output is zero while reset is held. A request at a clock edge gives `rsp_vld` high for exactly the following cycle. A cycle with no request gives `rsp_vld`, `rsp_fault` and `wb_vld` low in the following cycle.
- R2: The descriptor fields sit at fixed bit positions:
  - limit: bits 15:0 and 51:48;
  - base: bits 39:16 and 63:56;
  - access byte: bits 47:40, holding from the top down present, DPL (2 bits), non-system, executable, conforming/direction, readable/writable and accessed;
  - granularity: bit 55;
  - default/big: bit 54.

  A successful access returns `rsp_lin` equal to base plus offset modulo 2^32, with `rsp_fault` = 0 and `rsp_cause` = 0.
- R3: If the present bit is 0, the access faults with cause 1, whatever else is wrong.
- R4: Type faults give cause 4. They are raised for:
  - a non-system bit of 0;
  - access kind 3, which is reserved;
  - a write (kind 1) to code;
  - a read (kind 0) of code whose readable bit is 0;
  - a fetch (kind 2) from data;
  - a write to data whose writable bit is 0.
- R5: Privilege faults give cause 3. Data faults when CPL > DPL. Non-conforming code faults when CPL != DPL. Conforming code faults when CPL < DPL.
- R6: With granularity 0 the limit counts bytes. An expand-up segment (all code, and data with direction 0) faults with cause 2 when the offset exceeds the limit.
- R7: With granularity 1 the effective limit is the 20-bit limit shifted left by 12, with the low 12 bits filled with ones.
- R8: An expand-down data segment (direction 1) accepts only offsets above the effective limit and no higher than the upper bound. The upper bound is 0xFFFF when bit 54 is 0 and 0xFFFFFFFF when it is 1. Any other offset faults with cause 2.
- R9: When several faults apply, the cause reported follows the order not-present, then type, then privilege, then limit.
- R10: A successful access through a descriptor with the accessed bit (bit 40) at 0 raises `wb_vld` together with `wb_desc`, which equals the input descriptor with bit 40 set. A faulted access, or a descriptor whose accessed bit is already 1, leaves `wb_vld` low.
- R11: A faulted response carries `rsp_fault` = 1 and `rsp_lin` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Access request this cycle |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_cpl | input | 2 | Current privilege level |
| desc | input | 64 | Cached segment descriptor |
| rsp_vld | output | 1 | Result valid |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 3 | 0 none, 1 not present, 2 limit, 3 privilege, 4 type |
| rsp_lin | output | 32 | Linear address, or 0 on fault |
| wb_vld | output | 1 | Accessed-bit write-back request |
| wb_desc | output | 64 | Descriptor with the accessed bit set |

## Verification
Every result, meaning the fault flag, cause, linear address and write-back pair, is due exactly one clock edge after its request. The idle response is due one edge after a cycle with no request. The driver applies each request on a falling edge and queues the expected item at the same moment. The monitor pops and compares on the next falling edge, by which time the single register stage has been loaded. Back-to-back requests stay paired because the queue keeps them in order. Idle and reset checks sample one falling edge after the stimulus that causes them.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int DESC_W    = 64;
  localparam int ADDR_W    = 32;
  localparam int LIM_W     = 20;
  localparam int PAGE_BITS = ADDR_W - LIM_W;
  localparam int PL_W      = 2;
  localparam int CAUSE_W   = 3;
  localparam int ACC_BIT   = 40;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_ABSENT = 3'd1,
    CAUSE_LIMIT  = 3'd2,
    CAUSE_PRIV   = 3'd3,
    CAUSE_TYPE   = 3'd4
  } fault_cause_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  lim;
    logic              present;
    logic [PL_W-1:0]   dpl;
    logic              non_sys;
    logic              exec;
    logic              conf_dir;
    logic              rw;
    logic              accessed;
    logic              gran;
    logic              big;
  } seg_fields_t;

  // Granularity scaling of the 20-bit limit field.
  function automatic logic [ADDR_W-1:0] scaled_limit(input logic [LIM_W-1:0] lim,
                                                     input logic gran);
    if (gran) return {lim, {PAGE_BITS{1'b1}}};
    return {{PAGE_BITS{1'b0}}, lim};
  endfunction

  // Highest offset an expand-down segment may use.
  function automatic logic [ADDR_W-1:0] down_ceiling(input logic big);
    if (big) return {ADDR_W{1'b1}};
    return {{(ADDR_W-16){1'b0}}, 16'hFFFF};
  endfunction
endpackage

// File: rtl/seg_field_unpack.sv
module seg_field_unpack
  import seg_chk_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output seg_fields_t       fld
);
  always_comb begin
    fld.base     = {desc[63:56], desc[39:16]};
    fld.lim      = {desc[51:48], desc[15:0]};
    fld.present  = desc[47];
    fld.dpl      = desc[46:45];
    fld.non_sys  = desc[44];
    fld.exec     = desc[43];
    fld.conf_dir = desc[42];
    fld.rw       = desc[41];
    fld.accessed = desc[ACC_BIT];
    fld.gran     = desc[55];
    fld.big      = desc[54];
  end
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
  import seg_chk_pkg::*;
(
  input  seg_fields_t        fld,
  input  logic [ADDR_W-1:0]  off,
  input  logic [1:0]         kind,
  input  logic [PL_W-1:0]    cpl,
  output logic               absent_hit,
  output logic               type_hit,
  output logic               priv_hit,
  output logic               limit_hit,
  output logic [CAUSE_W-1:0] cause
);
  logic [ADDR_W-1:0] eff_lim;
  logic              expand_down;

  assign eff_lim     = scaled_limit(fld.lim, fld.gran);
  assign expand_down = !fld.exec && fld.conf_dir;
  assign absent_hit  = !fld.present;

  always_comb begin
    type_hit = 1'b0;
    if (!fld.non_sys || kind == KIND_RSVD) type_hit = 1'b1;
    else if (fld.exec)
      type_hit = (kind == KIND_WRITE) || (kind == KIND_READ && !fld.rw);
    else
      type_hit = (kind == KIND_FETCH) || (kind == KIND_WRITE && !fld.rw);
  end

  always_comb begin
    if (!fld.exec)         priv_hit = cpl > fld.dpl;
    else if (fld.conf_dir) priv_hit = cpl < fld.dpl;
    else                   priv_hit = cpl != fld.dpl;
  end

  always_comb begin
    if (expand_down) limit_hit = (off <= eff_lim) || (off > down_ceiling(fld.big));
    else             limit_hit = off > eff_lim;
  end

  always_comb begin
    if (absent_hit)     cause = CAUSE_ABSENT;
    else if (type_hit)  cause = CAUSE_TYPE;
    else if (priv_hit)  cause = CAUSE_PRIV;
    else if (limit_hit) cause = CAUSE_LIMIT;
    else                cause = CAUSE_NONE;
  end
endmodule

// File: rtl/seg_check_unit.sv
module seg_check_unit
  import seg_chk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic [31:0]        req_off,
  input  logic [1:0]         req_kind,
  input  logic [1:0]         req_cpl,
  input  logic [63:0]        desc,
  output logic               rsp_vld,
  output logic               rsp_fault,
  output logic [2:0]         rsp_cause,
  output logic [31:0]        rsp_lin,
  output logic               wb_vld,
  output logic [63:0]        wb_desc
);
  localparam logic [DESC_W-1:0] ACC_MASK = DESC_W'(1) << ACC_BIT;

  seg_fields_t        fld;
  logic               absent_hit, type_hit, priv_hit, limit_hit;
  logic [CAUSE_W-1:0] cause_c;
  logic               refuse;
  logic               need_wb;

  seg_field_unpack u_unpack (.desc(desc), .fld(fld));

  seg_rule_eval u_rules (
    .fld(fld), .off(req_off), .kind(req_kind), .cpl(req_cpl),
    .absent_hit(absent_hit), .type_hit(type_hit), .priv_hit(priv_hit),
    .limit_hit(limit_hit), .cause(cause_c)
  );

  assign refuse  = cause_c != CAUSE_NONE;
  assign need_wb = !refuse && !fld.accessed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_lin   <= '0;
      wb_vld    <= 1'b0;
      wb_desc   <= '0;
    end else begin
      rsp_vld   <= req_vld;
      rsp_fault <= req_vld && refuse;
      rsp_cause <= req_vld ? cause_c : '0;
      rsp_lin   <= (req_vld && !refuse) ? fld.base + req_off : '0;
      wb_vld    <= req_vld && need_wb;
      wb_desc   <= (req_vld && need_wb) ? (desc | ACC_MASK) : '0;
    end
  end

  a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rsp_vld && !wb_vld && !rsp_fault));
  a_r3_absent_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !desc[47]) |=> (rsp_fault && rsp_cause == CAUSE_ABSENT));
  a_r4_data_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && desc[47] && !desc[43] && req_kind == KIND_FETCH)
      |=> rsp_cause == CAUSE_TYPE);
  a_r6_byte_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && desc[47] && desc[44] && !desc[43] && !desc[42] && !desc[55]
     && req_kind == KIND_READ && req_cpl <= desc[46:45]
     && req_off > {12'b0, desc[51:48], desc[15:0]})
      |=> rsp_cause == CAUSE_LIMIT);
  a_r10_no_wb_when_set: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && desc[ACC_BIT]) |=> !wb_vld);
  a_r10_wb_only_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld |-> (rsp_vld && !rsp_fault));
  a_r11_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_lin == 32'd0);
endmodule

// File: tb/sim_seg_check_unit.sv
module sim_seg_check_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [31:0] req_off = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_cpl = '0;
  logic [63:0] desc = '0;
  logic        rsp_vld, rsp_fault, wb_vld;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_lin;
  logic [63:0] wb_desc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic        fault;
    logic [2:0]  cause;
    logic [31:0] lin;
    logic        wb;
    logic [63:0] wbd;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  seg_check_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_off(req_off),
    .req_kind(req_kind), .req_cpl(req_cpl), .desc(desc),
    .rsp_vld(rsp_vld), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_lin(rsp_lin), .wb_vld(wb_vld), .wb_desc(wb_desc)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                     input logic [7:0] acc, input bit g, input bit db);
    logic [63:0] d;
    d = '0;
    d[15:0]  = lim[15:0];
    d[51:48] = lim[19:16];
    d[39:16] = base[23:0];
    d[63:56] = base[31:24];
    d[47:40] = acc;
    d[55]    = g;
    d[54]    = db;
    return d;
  endfunction

  // Reference model written from the requirements.
  function automatic exp_t model(input logic [63:0] d, input logic [31:0] off,
                                 input logic [1:0] kind, input logic [1:0] cpl);
    exp_t e;
    longint unsigned lim, top, o;
    int dpl, pl;
    bit code, bad_type, bad_priv, bad_lim;
    o    = off;
    lim  = {d[51:48], d[15:0]};
    if (d[55]) lim = lim * 4096 + 4095;
    top  = d[54] ? 64'hFFFF_FFFF : 64'hFFFF;
    dpl  = d[46:45];
    pl   = cpl;
    code = d[43];
    bad_type = !d[44] || kind == 3 ||
               (code  && (kind == 1 || (kind == 0 && !d[41]))) ||
               (!code && (kind == 2 || (kind == 1 && !d[41])));
    if (!code)     bad_priv = pl > dpl;
    else if (d[42]) bad_priv = pl < dpl;
    else           bad_priv = pl != dpl;
    if (!code && d[42]) bad_lim = !(o > lim && o <= top);
    else                bad_lim = o > lim;
    e.cause = !d[47] ? 3'd1 : bad_type ? 3'd4 : bad_priv ? 3'd3 : bad_lim ? 3'd2 : 3'd0;
    e.fault = e.cause != 0;
    e.lin   = e.fault ? 32'd0 : 32'({d[63:56], d[39:16]} + off);
    e.wb    = !e.fault && !d[40];
    e.wbd   = e.wb ? {d[63:41], 1'b1, d[39:0]} : 64'd0;
    return e;
  endfunction

  task automatic send(input logic [63:0] d, input logic [31:0] off,
                      input logic [1:0] kind, input logic [1:0] cpl, input string tag);
    exp_t e;
    @(negedge clk);
    desc = d; req_off = off; req_kind = kind; req_cpl = cpl; req_vld = 1'b1;
    e = model(d, off, kind, cpl);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  // Monitor: compares each response one cycle after its request.
  always @(negedge clk) begin
    if (rst_n && rsp_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected rsp_vld", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_fault == e.fault, e.tag, "rsp_fault", 64'(rsp_fault), 64'(e.fault));
        chk(rsp_cause == e.cause, e.tag, "rsp_cause", 64'(rsp_cause), 64'(e.cause));
        chk(rsp_lin == e.lin, e.tag, "rsp_lin", 64'(rsp_lin), 64'(e.lin));
        chk(wb_vld == e.wb, e.tag, "wb_vld", 64'(wb_vld), 64'(e.wb));
        chk(wb_desc == e.wbd, e.tag, "wb_desc", wb_desc, e.wbd);
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] code0, data0;
    code0 = mk(32'h1000_0000, 20'hFFFFF, 8'h9A, 1, 1);
    data0 = mk(32'h0000_0000, 20'hFFFFF, 8'h92, 1, 1);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rsp_vld && !rsp_fault && rsp_cause == 0 && rsp_lin == 0 && !wb_vld && wb_desc == 0,
        "R1", "outputs in reset", {rsp_lin, 29'd0, rsp_cause}, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // R2 / R10: success, first access write-back
    send(code0, 32'h123, 2'd0, 2'd0, "R2_R10");
    send(mk(32'h1000_0000, 20'hFFFFF, 8'h9B, 1, 1), 32'h123, 2'd2, 2'd0, "R10_already_set");
    send(mk(32'hFFFF_F000, 20'hFFFFF, 8'h93, 1, 1), 32'h2000, 2'd1, 2'd0, "R2_wrap");
    // R4: type faults
    send(code0, 32'h10, 2'd1, 2'd0, "R4_code_write");
    send(data0, 32'h10, 2'd2, 2'd0, "R4_data_fetch");
    send(mk(0, 20'hFFFFF, 8'h90, 1, 1), 32'h10, 2'd1, 2'd0, "R4_ro_data_write");
    send(mk(0, 20'hFFFFF, 8'h98, 1, 1), 32'h10, 2'd0, 2'd0, "R4_xo_code_read");
    send(mk(0, 20'hFFFFF, 8'h82, 1, 1), 32'h10, 2'd0, 2'd0, "R4_system");
    send(data0, 32'h10, 2'd3, 2'd0, "R4_reserved_kind");
    // R3 / R9: absent wins over type
    send(mk(0, 20'hFFFFF, 8'h1A, 1, 1), 32'h10, 2'd1, 2'd3, "R3_R9_absent");
    // R5: privilege
    send(data0, 32'h10, 2'd0, 2'd3, "R5_data_cpl_gt");
    send(mk(0, 20'hFFFFF, 8'hF2, 1, 1), 32'h10, 2'd1, 2'd0, "R5_data_cpl_lt");
    send(code0, 32'h10, 2'd2, 2'd3, "R5_nc_low");
    send(mk(0, 20'hFFFFF, 8'hFA, 1, 1), 32'h10, 2'd2, 2'd0, "R5_nc_high");
    send(mk(0, 20'hFFFFF, 8'h9E, 1, 1), 32'h10, 2'd2, 2'd3, "R5_conf_ok");
    send(mk(0, 20'hFFFFF, 8'hFE, 1, 1), 32'h10, 2'd2, 2'd0, "R5_conf_bad");
    // R9: type over privilege, privilege over limit
    send(data0, 32'h10, 2'd2, 2'd3, "R9_type_first");
    send(mk(0, 20'h00FFF, 8'h92, 0, 1), 32'h5000, 2'd0, 2'd3, "R9_priv_first");
    // R6: byte granularity edge
    send(mk(32'h200, 20'h00FFF, 8'h92, 0, 1), 32'hFFF, 2'd0, 2'd0, "R6_at_limit");
    send(mk(32'h200, 20'h00FFF, 8'h92, 0, 1), 32'h1000, 2'd0, 2'd0, "R6_over");
    send(mk(32'h200, 20'h00FFF, 8'h9A, 0, 1), 32'h1000, 2'd2, 2'd0, "R6_code_over");
    // R7: page granularity edge
    send(mk(0, 20'h00001, 8'h92, 1, 1), 32'h1FFF, 2'd1, 2'd0, "R7_at_limit");
    send(mk(0, 20'h00001, 8'h92, 1, 1), 32'h2000, 2'd1, 2'd0, "R7_over");
    // R8: expand-down
    send(mk(32'h40, 20'h00FFF, 8'h96, 0, 1), 32'h0FFF, 2'd0, 2'd0, "R8_at_limit");
    send(mk(32'h40, 20'h00FFF, 8'h96, 0, 1), 32'h1000, 2'd0, 2'd0, "R8_above");
    send(mk(32'h40, 20'h00FFF, 8'h96, 0, 1), 32'hFFFF_FFFF, 2'd0, 2'd0, "R8_big_top");
    send(mk(32'h40, 20'h00FFF, 8'h96, 0, 0), 32'hFFFF, 2'd0, 2'd0, "R8_small_top");
    send(mk(32'h40, 20'h00FFF, 8'h96, 0, 0), 32'h1_0000, 2'd0, 2'd0, "R8_small_over");
    send(mk(32'h40, 20'h00001, 8'h96, 1, 1), 32'h1FFF, 2'd0, 2'd0, "R8_page_at");
    // R11 covered by the fault cases above; R1: idle after requests
    idle();
    @(negedge clk);
    chk(!rsp_vld && !wb_vld && !rsp_fault, "R1", "idle response",
        {61'd0, rsp_vld, wb_vld, rsp_fault}, 64'd0);
    send(code0, 32'h4, 2'd2, 2'd0, "R1_restart");
    idle();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1", "responses outstanding", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule